// File: doc/BRIEF.md
# Watchdog Countdown with Programmable Tick Prescaler

This block turns a fast reference clock into a slow, regular tick and uses that tick to pace a watchdog down-counter. A prescaler counts reference-clock cycles up to a programmed cycle count and emits a one-cycle tick on each wrap. With the count equal to the reference frequency in MHz, the tick period is one microsecond. The tick also leaves the block on its own pin, so that a separate system timer can use the same time base.

The watchdog counter is loaded by software through a load register and decrements once per tick while the control enable is set. Software must reload it again and again to keep it from expiring. When the counter reaches zero, the block raises a one-cycle reset request on each downstream reset target that a select mask enables. The counter then rests at zero until the next load. The current count is visible in the low bits of the control register. The block is held in reset only by its own run/power reset input, never by the requests it produces.

Top module: `wdog_tick_unit`

## Requirements
- R1: After reset, the tick configuration, countdown enable, time field and select mask all read zero, and neither the tick output nor any reset request is asserted.
- R2: The tick configuration register (address 0) holds the cycle count N in bits [15:0] and the tick enable in bit 16. A write to it restarts the prescaler. With N > 0 and the enable set, the tick is high for exactly one cycle, first in the N-th cycle after the write and then every N cycles.
- R3: No tick is produced while the tick enable bit is clear or while N is zero.
- R4: A write to the load register (address 1) places wr_data[23:0] into the counter, readable as bits [23:0] of the control register (address 2) in the next cycle.
- R5: The counter decrements by one at the end of each tick cycle only while the countdown enable (control register bit 31) is set. While the enable is clear, the value holds.
- R6: When a decrement takes the counter from one to zero, the reset request vector equals the select mask for exactly one cycle: the first cycle in which the time field reads zero. The counter then holds at zero and raises no further request until it is reloaded.
- R7: A reset request bit whose select mask bit (register address 3, bits [3:0]) is clear is never asserted.
- R8: If a load write and a tick fall in the same cycle, the loaded value is kept without a decrement.
- R9: Loading zero never produces a reset request.
- R10: The tick configuration and the select mask read back as written, and the countdown enable reads back in control bit 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low run/power reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 tick config, 1 load, 2 control, 3 select mask |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 32 | Read data (combinational) |
| tick_o | output | 1 | One-cycle tick pulse for the watchdog and the system timer |
| rst_req_o | output | 4 | Per-target reset requests, gated by the select mask |

## Verification
The bench measures the tick phase against the configuration write. A prescaler that is off by one, or that is not restarted by the write, shifts every tick. It follows the counter to zero and checks that the request appears in the exact cycle the time field first reads zero and only once. A design that re-fires at zero, or that asserts unselected targets, fails there. A load that lands in a tick cycle catches a design that lets the decrement win. Loading zero and disabling the countdown catch spurious expiry and drifting counts.

// File: rtl/wd_pkg.sv
package wd_pkg;
  typedef enum logic [1:0] {
    REG_TICK = 2'd0,
    REG_LOAD = 2'd1,
    REG_CTRL = 2'd2,
    REG_MASK = 2'd3
  } wd_reg_e;
endpackage

// File: rtl/wd_prescaler.sv
module wd_prescaler #(
  parameter int CYC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CYC_W-1:0] cycles_i,
  input  logic             restart_i,
  output logic             tick_o
);
  logic [CYC_W-1:0] phase_q;
  logic             active;
  logic             wrap;

  function automatic logic [CYC_W-1:0] last_phase(logic [CYC_W-1:0] n);
    return n - CYC_W'(1);
  endfunction

  assign active = en_i && (cycles_i != '0);
  assign wrap   = active && (phase_q == last_phase(cycles_i));
  assign tick_o = wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 phase_q <= '0;
    else if (restart_i || !active || wrap) phase_q <= '0;
    else                         phase_q <= phase_q + CYC_W'(1);
  end
endmodule

// File: rtl/wd_countdown.sv
module wd_countdown #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] time_o,
  output logic             fire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             fire_q;
  logic             step;
  logic             expire;

  function automatic logic [CNT_W-1:0] dec_sat(logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - CNT_W'(1);
  endfunction

  assign step   = run_i && tick_i && !load_i;
  assign expire = step && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= expire;
      if (load_i)    cnt_q <= load_val_i;
      else if (step) cnt_q <= dec_sat(cnt_q);
    end
  end

  assign time_o = cnt_q;
  assign fire_o = fire_q;
endmodule

// File: rtl/wd_regs.sv
module wd_regs
  import wd_pkg::*;
#(
  parameter int DW    = 32,
  parameter int CYC_W = 16,
  parameter int CNT_W = 24,
  parameter int NRST  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [1:0]       rd_addr_i,
  output logic [DW-1:0]    rd_data_o,
  input  logic [CNT_W-1:0] time_i,
  output logic [CYC_W-1:0] cycles_o,
  output logic             tick_en_o,
  output logic             cfg_wr_o,
  output logic             load_o,
  output logic             run_o,
  output logic [NRST-1:0]  mask_o
);
  logic [CYC_W-1:0] cyc_q;
  logic             ten_q;
  logic             run_q;
  logic [NRST-1:0]  mask_q;
  logic             wr_ctrl;
  logic             wr_mask;

  assign cfg_wr_o = wr_en_i && (wr_addr_i == REG_TICK);
  assign load_o   = wr_en_i && (wr_addr_i == REG_LOAD);
  assign wr_ctrl  = wr_en_i && (wr_addr_i == REG_CTRL);
  assign wr_mask  = wr_en_i && (wr_addr_i == REG_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= '0;
      ten_q  <= 1'b0;
      run_q  <= 1'b0;
      mask_q <= '0;
    end else begin
      if (cfg_wr_o) begin
        cyc_q <= wr_data_i[CYC_W-1:0];
        ten_q <= wr_data_i[CYC_W];
      end
      if (wr_ctrl) run_q  <= wr_data_i[DW-1];
      if (wr_mask) mask_q <= wr_data_i[NRST-1:0];
    end
  end

  always_comb begin
    rd_data_o = '0;
    unique case (wd_reg_e'(rd_addr_i))
      REG_TICK: begin
        rd_data_o[CYC_W-1:0] = cyc_q;
        rd_data_o[CYC_W]     = ten_q;
      end
      REG_LOAD: rd_data_o = '0;
      REG_CTRL: begin
        rd_data_o[CNT_W-1:0] = time_i;
        rd_data_o[DW-1]      = run_q;
      end
      REG_MASK: rd_data_o[NRST-1:0] = mask_q;
      default:  rd_data_o = '0;
    endcase
  end

  assign cycles_o  = cyc_q;
  assign tick_en_o = ten_q;
  assign run_o     = run_q;
  assign mask_o    = mask_q;
endmodule

// File: rtl/wdog_tick_unit.sv
module wdog_tick_unit #(
  parameter int DW    = 32,
  parameter int CYC_W = 16,
  parameter int CNT_W = 24,
  parameter int NRST  = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [1:0]      wr_addr_i,
  input  logic [DW-1:0]   wr_data_i,
  input  logic [1:0]      rd_addr_i,
  output logic [DW-1:0]   rd_data_o,
  output logic            tick_o,
  output logic [NRST-1:0] rst_req_o
);
  logic [CYC_W-1:0] cyc_w;
  logic             tick_en_w;
  logic             cfg_wr_w;
  logic             load_w;
  logic             run_w;
  logic [NRST-1:0]  mask_w;
  logic [CNT_W-1:0] time_w;
  logic             tick_w;
  logic             fire_w;

  wd_regs #(.DW(DW), .CYC_W(CYC_W), .CNT_W(CNT_W), .NRST(NRST)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .time_i(time_w),
    .cycles_o(cyc_w), .tick_en_o(tick_en_w), .cfg_wr_o(cfg_wr_w),
    .load_o(load_w), .run_o(run_w), .mask_o(mask_w)
  );

  wd_prescaler #(.CYC_W(CYC_W)) u_presc (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(tick_en_w),
    .cycles_i(cyc_w), .restart_i(cfg_wr_w), .tick_o(tick_w)
  );

  wd_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_w), .tick_i(tick_w),
    .load_i(load_w), .load_val_i(wr_data_i[CNT_W-1:0]),
    .time_o(time_w), .fire_o(fire_w)
  );

  for (genvar g = 0; g < NRST; g++) begin : g_req
    assign rst_req_o[g] = fire_w && mask_w[g];
  end

  assign tick_o = tick_w;
endmodule

// File: rtl/wdog_tick_unit_chk.sv
module wdog_tick_unit_chk #(
  parameter int DW    = 32,
  parameter int CYC_W = 16,
  parameter int CNT_W = 24,
  parameter int NRST  = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [DW-1:0]    wr_data_i,
  input logic             tick_o,
  input logic [NRST-1:0]  rst_req_o,
  input logic [CYC_W-1:0] cyc_w,
  input logic             tick_en_w,
  input logic             cfg_wr_w,
  input logic             load_w,
  input logic             run_w,
  input logic [NRST-1:0]  mask_w,
  input logic [CNT_W-1:0] time_w
);
  // R2
  tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && cyc_w > CYC_W'(1) && !cfg_wr_w) |=> !tick_o);
  // R3
  tick_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (tick_en_w && cyc_w != '0));
  // R4
  load_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_w |=> (time_w == $past(wr_data_i[CNT_W-1:0])));
  // R5
  hold_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_w && !load_w) |=> $stable(time_w));
  // R6
  req_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_o != '0) |-> (time_w == '0));
  // R6
  req_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_o != '0) |=> (rst_req_o == '0));
  // R7
  req_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_o & ~mask_w) == '0);
endmodule

bind wdog_tick_unit wdog_tick_unit_chk #(
  .DW(DW), .CYC_W(CYC_W), .CNT_W(CNT_W), .NRST(NRST)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_data_i(wr_data_i), .tick_o(tick_o),
  .rst_req_o(rst_req_o), .cyc_w(cyc_w), .tick_en_w(tick_en_w),
  .cfg_wr_w(cfg_wr_w), .load_w(load_w), .run_w(run_w), .mask_w(mask_w),
  .time_w(time_w)
);

// File: tb/test_wdog_tick_unit.sv
`timescale 1ns/1ps
module test_wdog_tick_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = 2'd2;
  logic [31:0] rd_data;
  logic        tick;
  logic [3:0]  req;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wdog_tick_unit i_wdog_tick_unit (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .tick_o(tick), .rst_req_o(req)
  );

  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  function automatic logic [23:0] cur_time();
    return rd_data[23:0];
  endfunction

  task automatic t_reset();
    rd_addr = 2'd0; #1; chk(rd_data == 0, "R1 tick cfg", rd_data, 0);
    rd_addr = 2'd2; #1; chk(rd_data == 0, "R1 ctrl/time", rd_data, 0);
    rd_addr = 2'd3; #1; chk(rd_data == 0, "R1 mask", rd_data, 0);
    chk(tick == 0 && req == 0, "R1 outputs", {tick, req}, 0);
    rd_addr = 2'd2;
  endtask

  task automatic t_tick_period(input int n);
    int bad = 0;
    wr(2'd0, 32'h1_0000 | n);
    for (int k = 0; k < 3 * n + 1; k++) begin
      @(negedge clk);
      if (tick !== ((k % n) == n - 1)) bad++;
    end
    chk(bad == 0, "R2 tick period", bad, 0);
  endtask

  task automatic t_no_tick(input logic [31:0] cfg, input string r);
    int seen = 0;
    wr(2'd0, cfg);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (tick) seen++;
    end
    chk(seen == 0, r, seen, 0);
  endtask

  task automatic t_readback();
    wr(2'd0, 32'h1_0007); wr(2'd3, 32'h9); wr(2'd2, 32'h8000_0000);
    rd_addr = 2'd0; #1; chk(rd_data == 32'h1_0007, "R10 tick cfg", rd_data, 32'h1_0007);
    rd_addr = 2'd3; #1; chk(rd_data == 32'h9, "R10 mask", rd_data, 9);
    rd_addr = 2'd2; #1; chk(rd_data[31] == 1'b1, "R10 run bit", rd_data[31], 1);
    wr(2'd2, 0); wr(2'd0, 0);
  endtask

  task automatic t_countdown(input int l, input int n, input logic [3:0] m);
    int bad_t = 0;
    int bad_r = 0;
    int exp_t;
    wr(2'd0, 0); wr(2'd3, {28'd0, m}); wr(2'd1, l);
    chk(cur_time() == l, "R4 load visible", cur_time(), l);
    wr(2'd2, 32'h8000_0000);
    wr(2'd0, 32'h1_0000 | n);
    for (int k = 0; k < l * n + 3 * n; k++) begin
      @(negedge clk);
      exp_t = l - k / n;
      if (exp_t < 0) exp_t = 0;
      if (cur_time() != exp_t) bad_t++;
      if (req !== ((k == l * n) ? m : 4'b0)) bad_r++;
    end
    chk(bad_t == 0, "R5 decrement per tick / R6 hold at zero", bad_t, 0);
    chk(bad_r == 0, "R6 single request / R7 mask", bad_r, 0);
  endtask

  task automatic t_disabled();
    int moved = 0;
    int reqs = 0;
    wr(2'd2, 0); wr(2'd0, 32'h1_0002); wr(2'd1, 5);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (cur_time() != 5) moved++;
      if (req != 0) reqs++;
    end
    chk(moved == 0 && reqs == 0, "R5 hold while disabled", moved + reqs, 0);
  endtask

  task automatic t_load_vs_tick();
    int guard = 0;
    wr(2'd1, 20); wr(2'd2, 32'h8000_0000); wr(2'd0, 32'h1_0004);
    @(negedge clk);
    while (!tick && guard < 50) begin @(negedge clk); guard++; end
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'd7;
    @(posedge clk); #1; wr_en = 1'b0;
    @(negedge clk);
    chk(cur_time() == 7, "R8 load beats tick", cur_time(), 7);
  endtask

  task automatic t_load_zero();
    int reqs = 0;
    wr(2'd3, 32'hF); wr(2'd2, 32'h8000_0000); wr(2'd0, 32'h1_0002);
    wr(2'd1, 0);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (req != 0) reqs++;
    end
    chk(reqs == 0 && cur_time() == 0, "R9 zero load no request", reqs, 0);
  endtask

  task automatic t_reload_refires();
    int hits = 0;
    wr(2'd3, 32'h2); wr(2'd0, 32'h1_0001); wr(2'd1, 3);
    for (int k = 0; k < 10; k++) begin @(negedge clk); if (req == 4'h2) hits++; end
    wr(2'd1, 2);
    for (int k = 0; k < 10; k++) begin @(negedge clk); if (req == 4'h2) hits++; end
    chk(hits == 2, "R6 one request per expiry after reload", hits, 2);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tick_period(5);
    t_tick_period(1);
    t_no_tick(32'h0000_0004, "R3 enable clear");
    t_no_tick(32'h1_0000, "R3 zero cycles");
    t_readback();
    t_countdown(3, 2, 4'b0101);
    t_countdown(2, 3, 4'b1010);
    t_disabled();
    t_load_vs_tick();
    t_load_zero();
    t_reload_refires();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule